// File: doc/BRIEF.md
# Counter-Tap Beep Tone Generator

This block makes a square-wave audio tone by watching one bit of a counter that never stops. The counter steps once every two system clocks. Software writes a tone-select register. That register holds a mask of counter bits, and the lowest bit set in it picks the counter bit that drives the speaker line. A one-bit enable in a separate control register switches the tone on and off. The enable only opens or closes while the chosen counter bit is low, so every high pulse on the output has its full length.

The system clock may run at full rate, at half rate or at one thirty-second of full rate. A two-bit ratio code tells the block which rate is in use. The block then moves the tap toward the least significant bit by one position at half rate and by five positions at the slowest rate, so the pitch heard stays the same. If that move would go below counter bit 0, the tap stays at bit 0.

Top module: `beep_tone_gen`

## Requirements
- R1: After reset the counter steps by exactly one every second clock, so counter bit k toggles every 2^(k+1) clocks.
- R2: The tone-select register (address 1) keeps only bits SEL_LSB+SEL_W-1:SEL_LSB of a write; the default is bits 18:10. Register bit b selects counter bit b. Every other bit is ignored on write and reads as zero.
- R3: In the control register (address 0), bit 0 is the enable. Every other read bit is zero, and writes to those bits have no effect.
- R4: At ratio code 0 (full rate), with lowest selected bit n, the output is a square wave that is high for 2^(n+1) clocks and low for 2^(n+1) clocks. For bit 10 the full period is therefore 2^12 clocks.
- R5: When several select bits are set, the lowest set bit alone sets the tone.
- R6: When no select bit is set, the output stays low even while it is enabled.
- R7: Ratio code 1 (half rate) moves the tap to bit n-1. Ratio code 2 (1/32 rate) moves it to bit n-5. Ratio code 3 acts like code 0.
- R8: A tap move that would go below counter bit 0 stops at bit 0, which gives a half-period of 2 clocks.
- R9: The enable opens and closes only while the tapped bit is low. After enabling, the first high pulse has full length. After disabling, a pulse already in progress completes at full length and the output then stays low.
- R10: Reset clears both registers and the counter and drives the output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 control, 1 tone select |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read target: 0 control, 1 tone select |
| rd_data | output | 32 | Read data, combinational |
| clk_ratio | input | 2 | Current clock ratio: 0 full, 1 half, 2 one thirty-second, 3 full |
| beep | output | 1 | Tone output |

## Verification
The bench builds the block with SEL_LSB set to 2, which gives a 9-bit field at register bits 10:2 and an 11-bit counter. With this base the slowest-rate shift can push the tap below bit 0, so the saturation case can be tested. Short taps give half-periods of a few clocks, while bit 10 still exercises a 2048-clock half-period. Enough tone periods then fit into one run to measure high and low times exactly for each ratio code.

// File: rtl/beep_pkg.sv
package beep_pkg;

    localparam int REG_W        = 32;
    localparam int SHIFT_HALF   = 1;
    localparam int SHIFT_SLOW32 = 5;

    typedef enum logic [1:0] {
        RATIO_FULL   = 2'd0,
        RATIO_HALF   = 2'd1,
        RATIO_SLOW32 = 2'd2,
        RATIO_SPARE  = 2'd3
    } ratio_e;

    typedef enum logic {
        ADDR_CTRL = 1'b0,
        ADDR_TONE = 1'b1
    } reg_addr_e;

    typedef struct packed {
        logic       hit;
        logic [7:0] idx;
    } tap_t;

    function automatic int ratio_shift(input ratio_e r);
        case (r)
            RATIO_HALF:   return SHIFT_HALF;
            RATIO_SLOW32: return SHIFT_SLOW32;
            default:      return 0;
        endcase
    endfunction

endpackage

// File: rtl/beep_regs.sv
module beep_regs
    import beep_pkg::*;
#(
    parameter int SEL_LSB = 10,
    parameter int SEL_W   = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rd_data,
    output logic             enable,
    output logic [SEL_W-1:0] sel_mask
);

    logic             en_q;
    logic [SEL_W-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            sel_q <= '0;
        end else if (wr_en) begin
            if (reg_addr_e'(wr_addr) == ADDR_TONE)
                sel_q <= wr_data[SEL_LSB +: SEL_W];
            else
                en_q <= wr_data[0];
        end
    end

    always_comb begin
        rd_data = '0;
        if (reg_addr_e'(rd_addr) == ADDR_TONE)
            rd_data[SEL_LSB +: SEL_W] = sel_q;
        else
            rd_data[0] = en_q;
    end

    assign enable   = en_q;
    assign sel_mask = sel_q;

endmodule

// File: rtl/beep_counter.sv
module beep_counter #(
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] count
);

    logic             phase_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            phase_q <= ~phase_q;
            if (phase_q)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/beep_tap_sel.sv
module beep_tap_sel
    import beep_pkg::*;
#(
    parameter int SEL_LSB = 10,
    parameter int SEL_W   = 9
) (
    input  logic [SEL_W-1:0] sel_mask,
    input  ratio_e           ratio,
    output tap_t             tap
);

    int low;
    int base;
    int shift;

    always_comb begin
        low = 0;
        for (int i = SEL_W - 1; i >= 0; i--) begin
            if (sel_mask[i])
                low = i;
        end
        base  = SEL_LSB + low;
        shift = ratio_shift(ratio);
        tap.hit = |sel_mask;
        if (base > shift)
            tap.idx = 8'(base - shift);
        else
            tap.idx = 8'd0;
    end

endmodule

// File: rtl/beep_tone_gen.sv
module beep_tone_gen
    import beep_pkg::*;
#(
    parameter int SEL_LSB = 10,
    parameter int SEL_W   = 9
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_addr,
    input  logic [31:0] wr_data,
    input  logic        rd_addr,
    output logic [31:0] rd_data,
    input  logic [1:0]  clk_ratio,
    output logic        beep
);

    localparam int CNT_W = SEL_LSB + SEL_W;

    logic             enable;
    logic [SEL_W-1:0] sel_mask;
    logic [CNT_W-1:0] cnt_w;
    tap_t             tap;
    logic             tap_bit;
    logic             gate_q;
    logic             beep_q;

    beep_regs #(.SEL_LSB(SEL_LSB), .SEL_W(SEL_W)) i_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .enable(enable), .sel_mask(sel_mask)
    );

    beep_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst(rst), .count(cnt_w)
    );

    beep_tap_sel #(.SEL_LSB(SEL_LSB), .SEL_W(SEL_W)) i_tap (
        .sel_mask(sel_mask), .ratio(ratio_e'(clk_ratio)), .tap(tap)
    );

    assign tap_bit = tap.hit & cnt_w[tap.idx];

    // gate changes only while the tapped bit is low: no clipped pulses
    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
            beep_q <= 1'b0;
        end else begin
            if (!tap_bit)
                gate_q <= enable;
            beep_q <= gate_q & tap_bit;
        end
    end

    assign beep = beep_q;

endmodule

// File: rtl/beep_tone_chk.sv
module beep_tone_chk #(
    parameter int CNT_W   = 19,
    parameter int SEL_LSB = 10,
    parameter int SEL_W   = 9
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt,
    input logic             tap_hit,
    input logic             tap_bit,
    input logic             gate,
    input logic             beep,
    input logic             rd_addr,
    input logic [31:0]      rd_data
);

    localparam logic [31:0] FIELD = ((32'd1 << SEL_W) - 32'd1) << SEL_LSB;

    p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt)) |-> (cnt == CNT_W'($past(cnt) + 1'b1)));

    p_count_pace_r1: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt)) |-> ($past(cnt) == $past(cnt, 2)));

    p_tone_rsvd_r2: assert property (@(posedge clk) disable iff (rst)
        rd_addr |-> ((rd_data & ~FIELD) == 32'd0));

    p_ctrl_rsvd_r3: assert property (@(posedge clk) disable iff (rst)
        !rd_addr |-> (rd_data[31:1] == 31'd0));

    p_no_tap_low_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(tap_hit) |-> !beep);

    p_gate_at_low_r9: assert property (@(posedge clk) disable iff (rst)
        (gate != $past(gate)) |-> !$past(tap_bit));

endmodule

bind beep_tone_gen beep_tone_chk #(.CNT_W(CNT_W), .SEL_LSB(SEL_LSB), .SEL_W(SEL_W)) i_chk (
    .clk(clk), .rst(rst), .cnt(cnt_w), .tap_hit(tap.hit), .tap_bit(tap_bit),
    .gate(gate_q), .beep(beep), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/test_beep_tone_gen.sv
`timescale 1ns/1ps
module test_beep_tone_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_addr = 1'b0;
    logic [31:0] rd_data;
    logic [1:0]  clk_ratio = 2'd0;
    logic        beep;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    beep_tone_gen #(.SEL_LSB(2), .SEL_W(9)) i_beep_tone_gen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .clk_ratio(clk_ratio), .beep(beep)
    );

    typedef struct packed {
        logic [31:0] sel;
        logic [1:0]  ratio;
        logic [31:0] half;
    } vec_t;

    // field at bits 10:2, register bit b -> counter bit b, half = 2^(tap+1)
    localparam vec_t VEC [10] = '{
        '{32'h0000_0004, 2'd0, 32'd8},    // R4 bit2
        '{32'h0000_0008, 2'd0, 32'd16},   // R4 bit3
        '{32'h0000_0400, 2'd0, 32'd2048}, // R4 bit10
        '{32'h0000_0030, 2'd0, 32'd32},   // R5 lowest of 4,5
        '{32'h0000_0008, 2'd1, 32'd8},    // R7 half: 3->2
        '{32'h0000_0080, 2'd2, 32'd8},    // R7 slow: 7->2
        '{32'h0000_0010, 2'd2, 32'd2},    // R8 4-5 saturates at 0
        '{32'h0000_0004, 2'd1, 32'd4},    // R7 half: 2->1
        '{32'h0000_0040, 2'd3, 32'd128},  // R7 code 3 as full
        '{32'hFFFF_F823, 2'd0, 32'd64}    // R2 outside bits ignored, bit5
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_rise(output bit ok);
        logic prev;
        ok = 1'b0;
        @(negedge clk);
        prev = beep;
        for (int k = 0; k < 10000; k++) begin
            @(negedge clk);
            if (beep && !prev) begin
                ok = 1'b1;
                break;
            end
            prev = beep;
        end
    endtask

    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (beep == lvl && n < 10000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        logic [31:0] d;
        bit ok;
        int hi, lo, t0;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        @(negedge clk);
        check(beep == 1'b0, "R10 beep low", {31'd0, beep}, 32'd0);
        rd(1'b0, d); check(d == 32'd0, "R10 ctrl", d, 32'd0);
        rd(1'b1, d); check(d == 32'd0, "R10 tone", d, 32'd0);

        // R2 / R3 readback masking
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, d); check(d == 32'h0000_07FC, "R2 tone readback", d, 32'h7FC);
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, d); check(d == 32'h0000_0001, "R3 ctrl readback", d, 32'h1);
        wr(1'b0, 32'hFFFF_FFFE);
        rd(1'b0, d); check(d == 32'h0000_0000, "R3 enable cleared", d, 32'h0);

        // table of tones: R4 R5 R7 R8 R2, first pulse full length (R9)
        foreach (VEC[i]) begin
            wr(1'b0, 32'd0);
            repeat (2100) @(negedge clk);
            check(beep == 1'b0, "R9 low after disable", {31'd0, beep}, 32'd0);
            clk_ratio = VEC[i].ratio;
            wr(1'b1, VEC[i].sel);
            wr(1'b0, 32'd1);
            wait_rise(ok);
            check(ok, "R4 tone starts", {31'd0, ok}, 32'd1);
            run_len(1'b1, hi);
            run_len(1'b0, lo);
            check(hi == int'(VEC[i].half), "R4 R7 R8 high time", hi, VEC[i].half);
            check(lo == int'(VEC[i].half), "R4 R7 R8 low time", lo, VEC[i].half);
        end

        // R6 no select bit: only bits outside field written, enabled
        wr(1'b0, 32'd0);
        repeat (2100) @(negedge clk);
        clk_ratio = 2'd0;
        wr(1'b1, 32'hFFFF_F803);
        wr(1'b0, 32'd1);
        hi = 0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (beep) hi++;
        end
        check(hi == 0, "R6 silent with empty field", hi, 0);

        // R9 disable mid-pulse: pulse completes, then stays low
        wr(1'b0, 32'd0);
        repeat (20) @(negedge clk);
        wr(1'b1, 32'h0000_0040);
        wr(1'b0, 32'd1);
        wait_rise(ok);
        t0 = cyc;
        repeat (10) @(negedge clk);
        wr(1'b0, 32'd0);
        while (beep && (cyc - t0) < 5000) @(negedge clk);
        check((cyc - t0) == 128, "R9 last pulse full", cyc - t0, 128);
        hi = 0;
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            if (beep) hi++;
        end
        check(hi == 0, "R9 held low when disabled", hi, 0);

        // R1 bit0 tap: half-period 2 clocks at slowest ratio, bit2
        clk_ratio = 2'd2;
        wr(1'b1, 32'h0000_0004);
        wr(1'b0, 32'd1);
        wait_rise(ok);
        run_len(1'b1, hi);
        check(hi == 2, "R1 counter bit0 pace", hi, 2);

        finish_run();
    end

endmodule